// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Read Engine

This block turns single-word bus reads into complete serial flash read transactions. The flash address space is cut into windows, one per chip select, each described by a start and an end in 8 MB units. On each accepted read the engine looks for the open window that contains the address. It subtracts that window's base to form the flash address. It then runs one full chip-select frame on a single-bit SPI link: opcode, three or four address bytes, an optional run of dummy bytes, and four data bytes. The assembled word goes back to the bus as if it came from ordinary memory.

The shape of each frame comes from that chip select's control word, which gives the opcode, the read mode, the dummy count, the SCK divider and the minimum idle time. A separate per-chip-select bit picks between 3-byte and 4-byte addressing. A read that falls in no open window is answered with an error and causes no SPI activity.

The controller is a five-state machine:
- `ST_IDLE`: accepts a request. A miss is answered at once. A hit latches the configuration, drives the chip select low and moves to `ST_SETUP`.
- `ST_SETUP`: holds SCK low for one divider period, then moves to `ST_SHIFT`.
- `ST_SHIFT`: clocks every bit of the frame. After the final falling SCK edge it moves to `ST_DONE`.
- `ST_DONE`: releases the chip select, returns the data and moves to `ST_GAP`.
- `ST_GAP`: waits out the idle time, then returns to `ST_IDLE`.

Top module: `flash_cmd_reader`

## Requirements
- R1: A read selects chip select `cs` when that window is open (start < end) and start <= `rd_addr[30:23]` < end. Window start is bits 23:16 and end is bits 31:24 of that chip select's window word. Addresses at or above 2 GB match no window. When several windows match, the lowest-numbered one wins. At most one `spi_cs_n` bit is ever low.
- R2: A read that matches no open window gives `rsp_valid` with `rsp_err`=1 and `rsp_data`=0 on the clock after acceptance. No chip select is asserted for it.
- R3: Every frame begins with the opcode in control bits 23:16, sent MSB first.
- R4: The opcode is followed by the flash address, which is the bus address minus (window start × 8 MB), sent MSB first. It is 4 bytes when `ce_4b[cs]` is 1 and otherwise its low 3 bytes.
- R5: When control bits 1:0 equal 1 (fast read), the number of dummy bytes after the address is {bit 14, bits 7:6}, at 8 SCK cycles each. Any other mode value sends no dummy bytes.
- R6: SCK idles low (mode 0). MOSI changes after falling edges and MISO is sampled on rising edges. Each SCK high phase lasts (control bits 11:8) + 1 bus clocks.
- R7: Four data bytes are read after the dummy bytes. The first byte received lands in `rsp_data[7:0]`, and later bytes fill higher lanes in order.
- R8: Each read is exactly one chip-select frame. The chip select is high again when the data response is given, and all chip selects then stay high for at least (control bits 27:24) + 1 bus clocks before the next frame.
- R9: During and just after reset, all chip selects are high, SCK is low, `rd_ready` is 1 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_req | input | 1 | Read request, taken when `rd_ready` is high |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_ready | output | 1 | Engine idle and able to take a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Response is an error (no window hit) |
| rsp_data | output | 8*DATA_BYTES | Read data, first flash byte in the low lane |
| ctl_cfg | input | 32*NCS | Per-chip-select control words |
| seg_cfg | input | 32*NCS | Per-chip-select window words |
| ce_4b | input | NCS | Per-chip-select 4-byte address enable |
| spi_cs_n | output | NCS | Active-low chip selects |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench drives a bit-level flash model and targets the following corner cases.

- **Overlapping windows:** a decoder that favours the highest index would select the wrong chip.
- **Closed and out-of-range windows:** a decoder that skips the start-below-end test would open a frame where an error is due.
- **Addressing width and fast-read decode:** switching between 3-byte and 4-byte addressing, and between modes with and without dummy bytes, catches a misplaced dummy field bit or a missing base subtraction. Either fault shows up as the model receiving the wrong address or as data shifted by whole bytes.
- **Byte lanes, SCK high time and idle gap:** a reversed lane order, a wrong divider or a skipped idle state would each yield a wrong word, a wrong pulse width or a gap that is too short.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_DONE,
        ST_GAP
    } rd_state_e;

    // Fields of a control word that shape one read frame
    typedef struct packed {
        logic [7:0] opcode;
        logic       fast;
        logic [2:0] dummy;
        logic [3:0] div;
        logic [3:0] inact;
    } rd_cfg_t;

    localparam int CTL_W      = 32;
    localparam int UNIT_LSB   = 23;   // 8 MB window granularity
    localparam int UNIT_W     = 8;
    localparam int OPC_BITS   = 8;

    function automatic rd_cfg_t decode_ctl(input logic [CTL_W-1:0] c);
        rd_cfg_t r;
        r.opcode = c[23:16];
        r.fast   = (c[1:0] == 2'd1);
        r.dummy  = {c[14], c[7:6]};
        r.div    = c[11:8];
        r.inact  = c[27:24];
        return r;
    endfunction

endpackage

// File: rtl/fr_seg_decode.sv
module fr_seg_decode #(
    parameter int NCS    = 2,
    parameter int ADDR_W = 32,
    parameter int CSW    = $clog2(NCS)
) (
    input  logic [ADDR_W-1:0]                    addr,
    input  logic [NCS*flash_rd_pkg::CTL_W-1:0]   seg_cfg,
    output logic                                 hit,
    output logic [CSW-1:0]                       cs_idx,
    output logic [NCS-1:0]                       cs_sel,
    output logic [ADDR_W-1:0]                    flash_addr
);
    import flash_rd_pkg::*;

    logic [UNIT_W-1:0] unit;
    logic              in_range;
    logic [NCS-1:0]    win_hit;
    logic [UNIT_W-1:0] start_sel;

    assign unit     = UNIT_W'(addr >> UNIT_LSB);
    assign in_range = ((addr >> (UNIT_LSB + UNIT_W)) == '0);

    for (genvar g = 0; g < NCS; g++) begin : g_win
        logic [UNIT_W-1:0] w_start;
        logic [UNIT_W-1:0] w_end;
        assign w_start    = seg_cfg[g*CTL_W+16 +: UNIT_W];
        assign w_end      = seg_cfg[g*CTL_W+24 +: UNIT_W];
        assign win_hit[g] = in_range && (w_start < w_end) &&
                            (unit >= w_start) && (unit < w_end);
    end

    // Lowest index wins among overlapping windows
    always_comb begin
        cs_idx = '0;
        hit    = 1'b0;
        for (int i = NCS - 1; i >= 0; i--) begin
            if (win_hit[i]) begin
                cs_idx = CSW'(i);
                hit    = 1'b1;
            end
        end
    end

    assign cs_sel     = hit ? (NCS'(1) << cs_idx) : '0;
    assign start_sel  = seg_cfg[int'(cs_idx)*CTL_W+16 +: UNIT_W];
    assign flash_addr = addr - (ADDR_W'(start_sel) << UNIT_LSB);

endmodule

// File: rtl/fr_sck_tick.sv
module fr_sck_tick #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || clr || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/fr_read_fsm.sv
module fr_read_fsm #(
    parameter int NCS        = 2,
    parameter int CSW        = $clog2(NCS),
    parameter int ADDR_W     = 32,
    parameter int DATA_BYTES = 4
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                rd_req,
    input  logic                                hit,
    input  logic [CSW-1:0]                      cs_idx,
    input  logic [NCS-1:0]                      cs_sel,
    input  logic [ADDR_W-1:0]                   flash_addr,
    input  logic [NCS*flash_rd_pkg::CTL_W-1:0]  ctl_cfg,
    input  logic [NCS-1:0]                      ce_4b,
    input  logic                                tick,
    input  logic                                spi_miso,
    output logic                                tick_clr,
    output logic [3:0]                          div_q,
    output logic                                rd_ready,
    output logic                                rsp_valid,
    output logic                                rsp_err,
    output logic [8*DATA_BYTES-1:0]             rsp_data,
    output logic [NCS-1:0]                      spi_cs_n,
    output logic                                spi_sck,
    output logic                                spi_mosi
);
    import flash_rd_pkg::*;

    localparam int TX_W   = OPC_BITS + 32;
    localparam int RX_W   = 8 * DATA_BYTES;
    localparam int MAXB   = OPC_BITS + 32 + 8 * 7 + RX_W;
    localparam int BCW    = $clog2(MAXB + 1);

    rd_state_e         state, nstate;
    rd_cfg_t           cfg_q;
    logic [TX_W-1:0]   tx_q;
    logic [RX_W-1:0]   rx_q;
    logic [BCW-1:0]    bitcnt;
    logic [BCW-1:0]    total_q;
    logic [3:0]        gcnt;
    logic              last_bit;
    rd_cfg_t           cfg_new;
    logic [31:0]       fa32;

    assign cfg_new  = decode_ctl(ctl_cfg[int'(cs_idx)*CTL_W +: CTL_W]);
    assign fa32     = 32'(flash_addr);
    assign last_bit = (bitcnt == total_q);
    assign rd_ready = (state == ST_IDLE);
    assign tick_clr = (state == ST_IDLE);
    assign div_q    = cfg_q.div;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nstate;
    end

    // Transitions
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (rd_req && hit)                 nstate = ST_SETUP;
            ST_SETUP: if (tick)                          nstate = ST_SHIFT;
            ST_SHIFT: if (tick && spi_sck && last_bit)   nstate = ST_DONE;
            ST_DONE:                                     nstate = ST_GAP;
            ST_GAP:   if (gcnt == cfg_q.inact)           nstate = ST_IDLE;
            default:                                     nstate = ST_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            spi_cs_n  <= '1;
            spi_sck   <= 1'b0;
            spi_mosi  <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
            cfg_q     <= '0;
            tx_q      <= '0;
            rx_q      <= '0;
            bitcnt    <= '0;
            total_q   <= '0;
            gcnt      <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (rd_req && hit) begin
                        cfg_q    <= cfg_new;
                        spi_cs_n <= ~cs_sel;
                        bitcnt   <= '0;
                        rx_q     <= '0;
                        spi_mosi <= cfg_new.opcode[7];
                        if (ce_4b[cs_idx]) tx_q <= {cfg_new.opcode, fa32};
                        else               tx_q <= {cfg_new.opcode, fa32[23:0], 8'h00};
                        total_q  <= BCW'(OPC_BITS)
                                  + (ce_4b[cs_idx] ? BCW'(32) : BCW'(24))
                                  + (cfg_new.fast ? BCW'({cfg_new.dummy, 3'b000}) : BCW'(0))
                                  + BCW'(RX_W);
                    end else if (rd_req) begin
                        rsp_valid <= 1'b1;
                        rsp_err   <= 1'b1;
                        rsp_data  <= '0;
                    end
                end
                ST_SETUP: begin
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!spi_sck) begin
                            spi_sck <= 1'b1;
                            rx_q    <= {rx_q[RX_W-2:0], spi_miso};
                            bitcnt  <= bitcnt + 1'b1;
                        end else begin
                            spi_sck <= 1'b0;
                            if (!last_bit) begin
                                tx_q     <= tx_q << 1;
                                spi_mosi <= tx_q[TX_W-2];
                            end else begin
                                spi_mosi <= 1'b0;
                            end
                        end
                    end
                end
                ST_DONE: begin
                    spi_cs_n  <= '1;
                    rsp_valid <= 1'b1;
                    rsp_err   <= 1'b0;
                    for (int k = 0; k < DATA_BYTES; k++) begin
                        rsp_data[8*k +: 8] <= rx_q[8*(DATA_BYTES-1-k) +: 8];
                    end
                    gcnt <= '0;
                end
                ST_GAP: begin
                    gcnt <= gcnt + 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    // R1: never more than one chip select active
    assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~spi_cs_n));

    // R2: a miss yields an error response next cycle with all selects idle
    assert_miss_err_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_ready && !hit) |=> (rsp_valid && rsp_err && (&spi_cs_n)));

    // R6: serial clock stays low while no chip is selected
    assert_sck_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (&spi_cs_n) |-> !spi_sck);

    // R8: a data response coincides with a released frame
    assert_frame_end_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_err) |-> ((&spi_cs_n) && !spi_sck && !$stable(spi_cs_n)));

endmodule

// File: rtl/flash_cmd_reader.sv
module flash_cmd_reader #(
    parameter int NCS        = 2,
    parameter int ADDR_W     = 32,
    parameter int DATA_BYTES = 4,
    parameter int CSW        = $clog2(NCS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rd_req,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic                     rd_ready,
    output logic                     rsp_valid,
    output logic                     rsp_err,
    output logic [8*DATA_BYTES-1:0]  rsp_data,
    input  logic [32*NCS-1:0]        ctl_cfg,
    input  logic [32*NCS-1:0]        seg_cfg,
    input  logic [NCS-1:0]           ce_4b,
    output logic [NCS-1:0]           spi_cs_n,
    output logic                     spi_sck,
    output logic                     spi_mosi,
    input  logic                     spi_miso
);
    logic              hit;
    logic [CSW-1:0]    cs_idx;
    logic [NCS-1:0]    cs_sel;
    logic [ADDR_W-1:0] flash_addr;
    logic              tick;
    logic              tick_clr;
    logic [3:0]        div_q;

    fr_seg_decode #(.NCS(NCS), .ADDR_W(ADDR_W), .CSW(CSW)) u_dec (
        .addr       (rd_addr),
        .seg_cfg    (seg_cfg),
        .hit        (hit),
        .cs_idx     (cs_idx),
        .cs_sel     (cs_sel),
        .flash_addr (flash_addr)
    );

    fr_sck_tick #(.DIV_W(4)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (tick_clr),
        .div  (div_q),
        .tick (tick)
    );

    fr_read_fsm #(.NCS(NCS), .CSW(CSW), .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .rd_req     (rd_req),
        .hit        (hit),
        .cs_idx     (cs_idx),
        .cs_sel     (cs_sel),
        .flash_addr (flash_addr),
        .ctl_cfg    (ctl_cfg),
        .ce_4b      (ce_4b),
        .tick       (tick),
        .spi_miso   (spi_miso),
        .tick_clr   (tick_clr),
        .div_q      (div_q),
        .rd_ready   (rd_ready),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .rsp_data   (rsp_data),
        .spi_cs_n   (spi_cs_n),
        .spi_sck    (spi_sck),
        .spi_mosi   (spi_mosi)
    );

endmodule

// File: tb/sim_flash_cmd_reader.sv
`timescale 1ns/1ps
module sim_flash_cmd_reader;

    typedef struct {
        bit          err;
        int          cs;
        logic [7:0]  op;
        logic [31:0] faddr;
        logic [31:0] data;
        string       tag;
    } exp_t;

    typedef struct {
        int          cs;
        logic [7:0]  op;
        logic [31:0] addr;
    } frame_t;

    logic        clk = 0;
    logic        rst = 1;
    logic        rd_req = 0;
    logic [31:0] rd_addr = 0;
    logic        rd_ready, rsp_valid, rsp_err;
    logic [31:0] rsp_data;
    logic [31:0] ctl [2];
    logic [31:0] seg [2];
    logic [1:0]  four = 2'b00;
    logic [1:0]  spi_cs_n;
    logic        spi_sck, spi_mosi;
    logic        miso_r = 0;
    logic        cs_idle;

    int n_chk = 0;
    int n_bad = 0;
    exp_t   exp_q[$];
    frame_t frm_q[$];

    always #10 clk = ~clk;

    flash_cmd_reader u0 (
        .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ready(rd_ready), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_data(rsp_data), .ctl_cfg({ctl[1], ctl[0]}), .seg_cfg({seg[1], seg[0]}),
        .ce_4b(four), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(miso_r)
    );

    assign cs_idle = &spi_cs_n;

    function automatic logic [31:0] mk_ctl(input logic [7:0] op, input logic [1:0] mode,
                                           input logic [2:0] dm, input logic [3:0] dv,
                                           input logic [3:0] ina);
        return {4'b0, ina, op, 1'b0, dm[2], 2'b0, dv, dm[1:0], 4'b0, mode};
    endfunction

    function automatic logic [31:0] mk_seg(input logic [7:0] s, input logic [7:0] e);
        return {e, s, 16'h0};
    endfunction

    function automatic logic [7:0] fbyte(input int cs, input logic [31:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ ((cs == 0) ? 8'h3C : 8'hA5);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    int          mbit = 0;
    bit          mact = 0;
    int          mcs = 0;
    logic [7:0]  m_op;
    logic [31:0] m_addr;

    function automatic int m_ab(input int cs);
        return four[cs] ? 4 : 3;
    endfunction
    function automatic int m_dm(input int cs);
        return (ctl[cs][1:0] == 2'd1) ? int'({ctl[cs][14], ctl[cs][7:6]}) : 0;
    endfunction

    always @(negedge cs_idle) begin
        if (!rst) begin
            mact = 1; mbit = 0; m_op = 0; m_addr = 0;
            mcs = (spi_cs_n[0] == 1'b0) ? 0 : 1;
        end
    end

    always @(posedge cs_idle) begin
        if (mact) begin
            frame_t f;
            f.cs = mcs; f.op = m_op; f.addr = m_addr;
            frm_q.push_back(f);
            mact = 0;
        end
    end

    always @(posedge spi_sck) begin
        if (mact) begin
            if (mbit < 8) m_op = {m_op[6:0], spi_mosi};
            else if (mbit < 8 + 8 * m_ab(mcs)) m_addr = {m_addr[30:0], spi_mosi};
            mbit++;
        end
    end

    always @(negedge spi_sck) begin
        if (mact) begin
            int d;
            logic [7:0] b;
            d = mbit - (8 + 8 * m_ab(mcs) + 8 * m_dm(mcs));
            if (d >= 0) begin
                b = fbyte(mcs, m_addr + 32'(d / 8));
                miso_r = b[7 - (d % 8)];
            end else begin
                miso_r = 1'b0;
            end
        end
    end

    // ---------------- timing monitors (R6, R8) ----------------
    int hi_cnt = 0;
    int gap_cnt = 0;
    bit seen_frame = 0;
    bit prev_idle = 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (spi_sck) hi_cnt++;
            else if (hi_cnt > 0) begin
                chk(hi_cnt == int'(ctl[mcs][11:8]) + 1, "R6 sck high time", 64'(hi_cnt),
                    64'(int'(ctl[mcs][11:8]) + 1));
                hi_cnt = 0;
            end
            if (cs_idle) gap_cnt++;
            else if (prev_idle) begin
                if (seen_frame)
                    chk(gap_cnt >= 4, "R8 inactive gap", 64'(gap_cnt), 64'(4));
                seen_frame = 1;
                gap_cnt = 0;
            end
            prev_idle = cs_idle;
        end
    end

    // ---------------- scoreboard monitor ----------------
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            exp_t e;
            if (exp_q.size() == 0) begin
                chk(0, "R8 unexpected response", 64'(rsp_data), 64'(0));
            end else begin
                e = exp_q.pop_front();
                chk(rsp_err == e.err, {e.tag, " err flag"}, 64'(rsp_err), 64'(e.err));
                chk(rsp_data == e.data, {e.tag, " data"}, 64'(rsp_data), 64'(e.data));
                if (e.err) begin
                    chk(frm_q.size() == 0, "R2 no frame on miss", 64'(frm_q.size()), 64'(0));
                end else if (frm_q.size() == 0) begin
                    chk(0, "R8 missing frame", 64'(0), 64'(1));
                end else begin
                    frame_t f;
                    f = frm_q.pop_front();
                    chk(f.cs == e.cs, "R1 chip select", 64'(f.cs), 64'(e.cs));
                    chk(f.op == e.op, "R3 opcode", 64'(f.op), 64'(e.op));
                    chk(f.addr == e.faddr, "R4 flash address", 64'(f.addr), 64'(e.faddr));
                end
            end
        end
    end

    // ---------------- driver ----------------
    task automatic rd(input logic [31:0] a, input string tag);
        exp_t e;
        int   hitcs = -1;
        for (int c = 1; c >= 0; c--) begin
            logic [7:0] s, en;
            s  = seg[c][23:16];
            en = seg[c][31:24];
            if (a[31] == 1'b0 && s < en && a[30:23] >= s && a[30:23] < en) hitcs = c;
        end
        e.tag = tag;
        if (hitcs < 0) begin
            e.err = 1; e.cs = 0; e.op = 0; e.faddr = 0; e.data = 0;
        end else begin
            logic [31:0] fa;
            fa = a - ({24'h0, seg[hitcs][23:16]} << 23);
            if (!four[hitcs]) fa = fa & 32'h00FF_FFFF;
            e.err = 0; e.cs = hitcs; e.op = ctl[hitcs][23:16]; e.faddr = fa;
            for (int k = 0; k < 4; k++) e.data[8*k +: 8] = fbyte(hitcs, fa + 32'(k));
        end
        forever begin
            @(negedge clk);
            if (rd_ready) break;
        end
        exp_q.push_back(e);
        rd_req  = 1;
        rd_addr = a;
        @(negedge clk);
        rd_req  = 0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        ctl[0] = mk_ctl(8'h03, 2'd0, 3'd0, 4'd0, 4'd3);
        ctl[1] = mk_ctl(8'h0B, 2'd1, 3'd1, 4'd2, 4'd3);
        seg[0] = mk_seg(8'd0, 8'd2);
        seg[1] = mk_seg(8'd2, 8'd4);
        four   = 2'b10;
        repeat (4) @(negedge clk);
        // R9: reset state
        chk(spi_cs_n == 2'b11, "R9 cs idle in reset", 64'(spi_cs_n), 64'(3));
        chk(spi_sck == 1'b0, "R9 sck low in reset", 64'(spi_sck), 64'(0));
        rst = 0;
        @(negedge clk);
        chk(rd_ready == 1'b1, "R9 ready after reset", 64'(rd_ready), 64'(1));
        chk(rsp_valid == 1'b0, "R9 no response after reset", 64'(rsp_valid), 64'(0));

        // R3/R4/R7: normal read 3-byte on cs0, fast read 4-byte on cs1
        rd(32'h0000_0123, "R3 R7 cs0 normal");
        rd(32'h00AB_CDE0, "R4 cs0 upper window");
        rd(32'h0100_0456, "R5 cs1 fast 4-byte");
        rd(32'h01FF_FF00, "R4 cs1 end of window");
        // R2: misses
        rd(32'h0200_0000, "R2 beyond windows");
        rd(32'h8000_0010, "R2 above 2GB");
        rd(32'h0000_0200, "R7 after miss");
        drain();

        // R5: dummy count of five, and non-fast mode ignoring dummy field
        ctl[0] = mk_ctl(8'h3B, 2'd1, 3'd5, 4'd1, 4'd3);
        rd(32'h0000_0040, "R5 five dummy bytes");
        drain();
        ctl[0] = mk_ctl(8'h13, 2'd2, 3'd7, 4'd0, 4'd3);
        four   = 2'b11;
        rd(32'h0012_3456, "R5 mode 2 no dummy");
        drain();

        // R1: overlapping windows, lowest wins
        seg[0] = mk_seg(8'd0, 8'd4);
        rd(32'h0100_0010, "R1 overlap lowest wins");
        drain();
        // R1/R2: closed window falls through to cs1 or misses
        seg[0] = mk_seg(8'd3, 8'd3);
        rd(32'h0000_0010, "R2 closed window");
        rd(32'h0100_0010, "R1 closed window skipped");
        drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule